// File: doc/BRIEF.md
# Block-Adaptive Lattice Prediction-Error Filter

This block whitens a continuous stream of signed 16-bit samples with a chain of P lattice stages. Each stage holds one reflection coefficient and a one-sample delay on its backward path. The stage turns the forward and backward errors of the stage before it into new errors. Stage zero's forward and backward errors are both the raw input sample.

The coefficients are not adapted by gradient steps. A single shared estimator is switched from stage to stage. It starts at the first stage and moves one stage further each time it finishes. While it serves a stage, it takes that stage's forward input and delayed backward input over a window of N valid samples. From these it forms a cross-correlation sum and an energy sum. A sequential divider then turns the two sums into a Q1.15 coefficient, which is written into the stage. The estimator then moves to the next stage. After the last stage is written, a done flag rises and the coefficients stay fixed until a restart. A full adaptation needs P·N samples plus a short divide gap after each window.

The block is used as an on-line autoregressive analyser. The reflection coefficients are read from a flat output bus. The prediction errors stream out one cycle after each input sample.

Top module: `lat_pred_filter`

## Requirements
- R1: After reset, every coefficient is zero, adapt_o is 1 (stage 1 selected), done_o is low and valid_o is low.
- R2: For each stage j, forward out = fin + rnd(k_j·bd) and backward out = bd + rnd(k_j·fin). Here fin is the forward input of the current sample and bd is the stage's delayed backward input. rnd(p) is (p + 2^14) shifted right by 15 with arithmetic sign. Stage 0 takes x_i for both paths. ef_o and eb_o are the last stage's results, registered, and valid_o rises one cycle after valid_i.
- R3: Every stage output saturates to the range -32768..32767.
- R4: Each stage's backward delay loads its backward input only on a valid sample. With all coefficients at zero, ef_o equals the input and eb_o equals the input from P valid samples earlier.
- R5: The estimator serves the stage flagged in adapt_o (bit j-1 for stage j). It counts only that stage's next N valid samples and then computes k = -2·Σ(fin·bd) / Σ(fin² + bd²). The magnitude is the floor of 2|Σfin·bd|·2^15 / energy. The result is written into bits [(j-1)·16 +: 16] of k_o within 24 cycles of the N-th sample, and adapt_o moves to stage j+1. Samples that arrive during those 24 cycles are not counted.
- R6: A window with zero energy yields k = 0. A coefficient magnitude is clamped to 32767, and -32768 never appears.
- R7: Cycles with valid_i low have no effect: ef_o, eb_o, k_o and the estimator's window count stay as they were, and valid_o is low.
- R8: Once the last stage is written, done_o is high and adapt_o is zero. Later samples leave k_o unchanged but are still filtered.
- R9: restart_i clears all coefficients, all backward delays and the estimator, lowers done_o and selects stage 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Clear coefficients and begin adaptation again at stage 1 |
| valid_i | input | 1 | x_i holds a new sample |
| x_i | input | DW | Signed input sample |
| valid_o | output | 1 | ef_o and eb_o are new |
| ef_o | output | DW | Forward prediction error of the last stage |
| eb_o | output | DW | Backward prediction error of the last stage |
| k_o | output | P*KW | Reflection coefficients, stage j at bits [(j-1)*KW +: KW] |
| adapt_o | output | P | One-hot flag of the stage being estimated |
| done_o | output | 1 | All stages adapted |

## Verification
A wrong backward delay or a wrong rounding step shows on ef_o or eb_o in the very next valid cycle. This is because the bench recomputes every stage's output for each sample and compares the last stage with the ports. Faults in the estimator, such as a miscounted window, the wrong stage tap, a bad divider step or a lost sign, stay hidden until that window closes. About 24 cycles after the N-th sample they appear as a wrong word in k_o. Every later sample's errors then drift away from the model. A wrong restart or done handling appears at once in adapt_o, done_o and k_o.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    CU_ACC,
    CU_PREP,
    CU_DIV,
    CU_FIN
  } cu_state_e;
endpackage

// File: rtl/lat_stage.sv
module lat_stage #(
  parameter int DW = 16,
  parameter int KW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 adv_i,
  input  logic signed [DW-1:0] f_i,
  input  logic signed [DW-1:0] b_i,
  input  logic signed [KW-1:0] k_i,
  output logic signed [DW-1:0] f_o,
  output logic signed [DW-1:0] b_o,
  output logic signed [DW-1:0] bd_o
);
  localparam int PW = DW + KW;
  localparam logic signed [PW:0] HALF = (PW+1)'(1) <<< (KW-2);
  localparam logic signed [PW:0] MAXV = (PW+1)'((1 << (DW-1)) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - 1;

  logic signed [DW-1:0] bd_q;
  logic signed [PW-1:0] pf, pb;
  logic signed [PW:0]   sf, sb, tf, tb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bd_q <= '0;
    else if (clr_i) bd_q <= '0;
    else if (adv_i) bd_q <= b_i;
  end

  assign pf = k_i * bd_q;
  assign pb = k_i * f_i;
  assign sf = ((PW+1)'(pf) + HALF) >>> (KW-1);
  assign sb = ((PW+1)'(pb) + HALF) >>> (KW-1);
  assign tf = sf + (PW+1)'(f_i);
  assign tb = sb + (PW+1)'(bd_q);

  always_comb begin
    if (tf > MAXV)      f_o = MAXV[DW-1:0];
    else if (tf < MINV) f_o = MINV[DW-1:0];
    else                f_o = tf[DW-1:0];
    if (tb > MAXV)      b_o = MAXV[DW-1:0];
    else if (tb < MINV) b_o = MINV[DW-1:0];
    else                b_o = tb[DW-1:0];
  end

  assign bd_o = bd_q;

  // R4
  bd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(bd_q));
endmodule

// File: rtl/lat_coef_unit.sv
module lat_coef_unit
  import lat_pkg::*;
#(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int N  = 16,
  parameter int AW = 2*DW + $clog2(N) + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 en_i,
  input  logic                 adv_i,
  input  logic signed [DW-1:0] f_i,
  input  logic signed [DW-1:0] b_i,
  output logic                 k_vld_o,
  output logic signed [KW-1:0] k_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam int IW = $clog2(KW);
  localparam logic [KW-1:0] MAXK = KW'((1 << (KW-1)) - 1);

  cu_state_e            st_q;
  logic [CW-1:0]        cnt_q;
  logic signed [AW-1:0] num_q;
  logic [AW-1:0]        den_q;
  logic [AW:0]          rem_q, rem_n;
  logic [KW-1:0]        q_q, mag;
  logic [IW-1:0]        it_q;
  logic                 neg_q, zero_q, qbit;
  logic signed [2*DW-1:0] ff, bb, fb;
  logic signed [AW-1:0] absn;

  assign ff   = f_i * f_i;
  assign bb   = b_i * b_i;
  assign fb   = f_i * b_i;
  assign absn = num_q[AW-1] ? -num_q : num_q;
  assign qbit = rem_q >= {1'b0, den_q};
  assign rem_n = qbit ? rem_q - {1'b0, den_q} : rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CU_ACC; cnt_q <= '0; num_q <= '0; den_q <= '0;
      rem_q <= '0; q_q <= '0; it_q <= '0; neg_q <= 1'b0; zero_q <= 1'b0;
    end else if (clr_i) begin
      st_q <= CU_ACC; cnt_q <= '0; num_q <= '0; den_q <= '0;
      rem_q <= '0; q_q <= '0; it_q <= '0; neg_q <= 1'b0; zero_q <= 1'b0;
    end else begin
      case (st_q)
        CU_ACC: if (en_i && adv_i) begin
          num_q <= num_q + AW'(fb);
          den_q <= den_q + AW'($unsigned(ff)) + AW'($unsigned(bb));
          if (cnt_q == CW'(N-1)) begin
            cnt_q <= '0;
            st_q  <= CU_PREP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        CU_PREP: begin
          rem_q  <= {$unsigned(absn), 1'b0};
          neg_q  <= (num_q > 0);
          zero_q <= (den_q == '0);
          q_q    <= '0;
          it_q   <= '0;
          st_q   <= CU_DIV;
        end
        CU_DIV: begin
          rem_q <= rem_n << 1;
          q_q   <= {q_q[KW-2:0], qbit};
          it_q  <= it_q + 1'b1;
          if (it_q == IW'(KW-1)) st_q <= CU_FIN;
        end
        default: begin
          num_q <= '0;
          den_q <= '0;
          st_q  <= CU_ACC;
        end
      endcase
    end
  end

  assign mag     = zero_q ? '0 : ((q_q > MAXK) ? MAXK : q_q);
  assign k_vld_o = (st_q == CU_FIN);
  assign k_o     = neg_q ? -$signed(mag) : $signed(mag);

  // R6
  k_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_vld_o |-> (k_o != {1'b1, {(KW-1){1'b0}}}));
  // R5
  div_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CU_PREP) |=> (st_q == CU_DIV) || $past(clr_i));
endmodule

// File: rtl/lat_pred_filter.sv
module lat_pred_filter #(
  parameter int DW = 16,
  parameter int KW = 16,
  parameter int P  = 4,
  parameter int N  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            restart_i,
  input  logic            valid_i,
  input  logic [DW-1:0]   x_i,
  output logic            valid_o,
  output logic [DW-1:0]   ef_o,
  output logic [DW-1:0]   eb_o,
  output logic [P*KW-1:0] k_o,
  output logic [P-1:0]    adapt_o,
  output logic            done_o
);
  localparam int SW = (P > 1) ? $clog2(P) : 1;
  localparam int AW = 2*DW + $clog2(N) + 2;

  logic signed [DW-1:0] f_c [P+1];
  logic signed [DW-1:0] b_c [P+1];
  logic signed [DW-1:0] bd_c [P];
  logic signed [KW-1:0] k_q [P];
  logic signed [DW-1:0] tap_f, tap_b;
  logic signed [KW-1:0] k_new;
  logic                 k_vld;
  logic [SW-1:0]        sel_q;
  logic                 done_q, vld_q;
  logic [DW-1:0]        ef_q, eb_q;

  assign f_c[0] = $signed(x_i);
  assign b_c[0] = $signed(x_i);

  for (genvar j = 0; j < P; j++) begin : g_stage
    lat_stage #(.DW(DW), .KW(KW)) i_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (restart_i),
      .adv_i (valid_i),
      .f_i   (f_c[j]),
      .b_i   (b_c[j]),
      .k_i   (k_q[j]),
      .f_o   (f_c[j+1]),
      .b_o   (b_c[j+1]),
      .bd_o  (bd_c[j])
    );
    assign k_o[j*KW +: KW] = k_q[j];
    assign adapt_o[j]      = !done_q && (sel_q == SW'(j));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              k_q[j] <= '0;
      else if (restart_i)                       k_q[j] <= '0;
      else if (k_vld && (sel_q == SW'(j)))      k_q[j] <= k_new;
    end

    // R5
    unadapted_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!done_q && (sel_q <= SW'(j))) |-> (k_q[j] == '0));
  end

  always_comb begin
    tap_f = '0;
    tap_b = '0;
    for (int j = 0; j < P; j++) begin
      if (sel_q == SW'(j)) begin
        tap_f = f_c[j];
        tap_b = bd_c[j];
      end
    end
  end

  lat_coef_unit #(.DW(DW), .KW(KW), .N(N), .AW(AW)) i_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart_i),
    .en_i   (!done_q),
    .adv_i  (valid_i),
    .f_i    (tap_f),
    .b_i    (tap_b),
    .k_vld_o(k_vld),
    .k_o    (k_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i) begin
      sel_q  <= '0;
      done_q <= 1'b0;
    end else if (k_vld && !done_q) begin
      if (sel_q == SW'(P-1)) done_q <= 1'b1;
      else                   sel_q  <= sel_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ef_q  <= '0;
      eb_q  <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        ef_q <= f_c[P];
        eb_q <= b_c[P];
      end
    end
  end

  assign valid_o = vld_q;
  assign ef_o    = ef_q;
  assign eb_o    = eb_q;
  assign done_o  = done_q;

  // R5
  adapt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $onehot(adapt_o));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> (done_o && $stable(k_o) && (adapt_o == '0)));
  // R9
  restart_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> ((k_o == '0) && !done_o && (adapt_o == P'(1))));
endmodule

// File: tb/test_lat_pred_filter.sv
module test_lat_pred_filter;
  localparam int P = 3;
  localparam int N = 8;
  localparam int NV = P*N;
  localparam logic signed [15:0] VEC [NV] = '{
    16'sd1200, 16'sd5300, 16'sd8100, 16'sd6400, 16'sd1500, -16'sd3900, -16'sd7700, -16'sd7200,
    -16'sd2600, 16'sd2900, 16'sd7000, 16'sd7600, 16'sd3800, -16'sd1800, -16'sd6500, -16'sd7900,
    -16'sd4700, 16'sd800, 16'sd5900, 16'sd8000, 16'sd5500, 16'sd100, -16'sd5200, -16'sd7800
  };

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, valid = 1'b0;
  logic [15:0] x = '0;
  logic valid_o, done_o;
  logic [15:0] ef_o, eb_o;
  logic [P*16-1:0] k_o;
  logic [P-1:0] adapt_o;

  int total = 0, bad = 0;
  bit finished = 0;

  longint k_m [P];
  longint bd_m [P];
  longint num_m, den_m, ef_m, eb_m;
  int cur_m, cnt_m;
  bit done_m;

  always #5 clk = ~clk;

  lat_pred_filter #(.DW(16), .KW(16), .P(P), .N(N)) i_lat_pred_filter (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .valid_i(valid), .x_i(x),
    .valid_o(valid_o), .ef_o(ef_o), .eb_o(eb_o), .k_o(k_o), .adapt_o(adapt_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rnd(input longint p);
    return (p + 16384) >>> 15;
  endfunction

  function automatic longint kdut(input int j);
    return longint'($signed(k_o[j*16 +: 16]));
  endfunction

  task automatic model_clear();
    for (int j = 0; j < P; j++) begin k_m[j] = 0; bd_m[j] = 0; end
    num_m = 0; den_m = 0; cur_m = 0; cnt_m = 0; done_m = 0;
  endtask

  task automatic model_step(input longint xs);
    longint f, b, nf, nb, bo, mag;
    f = xs; b = xs;
    for (int j = 0; j < P; j++) begin
      bo = bd_m[j];
      if (!done_m && j == cur_m) begin
        num_m += f * bo;
        den_m += f * f + bo * bo;
      end
      nf = sat16(f + rnd(k_m[j] * bo));
      nb = sat16(bo + rnd(k_m[j] * f));
      bd_m[j] = b;
      f = nf; b = nb;
    end
    ef_m = f; eb_m = b;
    if (!done_m) begin
      cnt_m++;
      if (cnt_m == N) begin
        if (den_m == 0) mag = 0;
        else begin
          mag = ((num_m < 0 ? -num_m : num_m) * 2 * 32768) / den_m;
          if (mag > 32767) mag = 32767;
        end
        k_m[cur_m] = (num_m > 0) ? -mag : mag;
        num_m = 0; den_m = 0; cnt_m = 0;
        if (cur_m == P-1) done_m = 1; else cur_m++;
      end
    end
  endtask

  // one valid sample; outputs checked one cycle later (R2, R4)
  task automatic drive(input logic signed [15:0] xs);
    x = xs; valid = 1'b1;
    model_step(longint'(xs));
    @(posedge clk); @(negedge clk);
    chk("R2 valid_o", valid_o, 1);
    chk("R2 ef_o", longint'($signed(ef_o)), ef_m);
    chk("R4 eb_o", longint'($signed(eb_o)), eb_m);
  endtask

  task automatic idle(input int n);
    valid = 1'b0; x = 16'h5a5a;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_coefs(input string tag);
    for (int j = 0; j < P; j++) chk(tag, kdut(j), k_m[j]);
    chk({tag, " adapt"}, adapt_o, done_m ? 0 : (1 << cur_m));
    chk({tag, " done"}, done_o, done_m);
  endtask

  task automatic do_restart();
    restart = 1'b1; @(posedge clk); @(negedge clk); restart = 1'b0;
    model_clear();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ef_h, eb_h, k_h0;
    bit rail;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 k_o", k_o, 0);
    chk("R1 adapt_o", adapt_o, 1);
    chk("R1 done_o", done_o, 0);
    chk("R1 valid_o", valid_o, 0);

    // table walk: P windows, coefficient checked after each (R5, R2, R4)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      if ((i % N) == N-1) begin
        ef_h = longint'($signed(ef_o)); eb_h = longint'($signed(eb_o));
        idle(24);
        chk_coefs("R5 k_o");
        // R7 idle cycles with garbage input change nothing
        chk("R7 valid_o", valid_o, 0);
        chk("R7 ef_o", longint'($signed(ef_o)), ef_h);
        chk("R7 eb_o", longint'($signed(eb_o)), eb_h);
      end
    end
    chk("R8 done_o", done_o, 1);
    chk("R8 adapt_o", adapt_o, 0);

    // R8 further samples: still filtered, coefficients frozen
    for (int i = 0; i < N+2; i++) drive(VEC[(i*5) % NV]);
    idle(24);
    chk_coefs("R8 k_o");

    // R9 restart clears coefficients, delays and the estimator
    do_restart();
    chk("R9 k_o", k_o, 0);
    chk("R9 adapt_o", adapt_o, 1);
    chk("R9 done_o", done_o, 0);
    // R4 with zero coefficients: ef = x, eb = x delayed P samples (delays cleared)
    drive(16'sd1000);
    chk("R4 passthru ef", longint'($signed(ef_o)), 1000);
    chk("R4 passthru eb", longint'($signed(eb_o)), 0);

    // R6 zero-energy window yields k = 0
    do_restart();
    for (int i = 0; i < N; i++) drive(16'sd0);
    idle(24);
    chk("R6 zero k1", kdut(0), 0);
    chk("R6 zero adapt", adapt_o, 2);
    chk_coefs("R6 k_o");

    // R3 saturation: constant windows give negative k1, then full-scale alternation
    do_restart();
    for (int s = 0; s < P; s++) begin
      for (int i = 0; i < N; i++) drive(16'sd20000);
      idle(24);
    end
    chk_coefs("R3 setup k_o");
    k_h0 = kdut(0);
    chk("R5 const k1", k_h0, -30583);
    rail = 0;
    for (int i = 0; i < 6; i++) begin
      drive((i % 2) ? -16'sd32768 : 16'sd32767);
      if ($signed(ef_o) == 32767 || $signed(ef_o) == -32768 ||
          $signed(eb_o) == 32767 || $signed(eb_o) == -32768) rail = 1;
    end
    chk("R3 rail reached", rail, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule